// File: doc/BRIEF.md
# H-Bridge Phase and Chopper Control

This block controls one winding of a bipolar stepper motor. It decides which of the four H-bridge transistors may conduct, and it regulates the winding current by chopping only the low-side (sink) transistors. Enable and phase pick the bridge diagonal. When phase changes, a dead time holds the whole bridge off before the other diagonal turns on. A fault on any of three flags shuts the bridge down, and the bridge recovers on its own once every flag clears.

Current regulation uses a set/reset latch. A current-limit flag (winding current above the nominal value) clears the latch, and only the sink gates follow the latch. The latch is set again in one of two ways. In free-running mode, a fixed charge interval always runs to its end, then a fixed off interval runs. In sync mode, a falling edge on an external trigger sets the latch, but only while the current is below nominal and no dead time is in progress. The analog comparator, the RC timing network and the power stage are outside this block and appear only as digital inputs. Every asynchronous input passes through a multi-flop synchronizer.

Top module: `hbridge_chop_ctrl`

## Requirements
- R1: While the synchronized enable is low, all four gate outputs are 0. After reset every gate output is 0.
- R2: With enable high, phase low and the latch set, the output vector {src1_o,src2_o,snk1_o,snk2_o} is 4'b0110 (high side of leg 2 and low side of leg 1 on).
- R3: With enable high, phase high and the latch set, the output vector {src1_o,src2_o,snk1_o,snk2_o} is 4'b1001 (high side of leg 1 and low side of leg 2 on).
- R4: After a phase change while enabled, all four gates are 0 for exactly DEAD_CYC clock cycles. The other diagonal then turns on. A source gate and the sink gate of the same leg are never 1 together.
- R5: When the current-limit flag is seen, both sink gates turn off and the active source gate stays on.
- R6: In free-running mode, a current-limit event after the charge interval has finished keeps the sink off for exactly OFF_CYC cycles. The sink then turns on again.
- R7: In free-running mode, the charge interval of CHG_CYC cycles, counted from sink turn-on, always finishes before the off interval starts. A current-limit event right after turn-on therefore gives CHG_CYC+OFF_CYC cycles from one sink turn-on to the next.
- R8: In sync mode (sync_mode_i = 1), no timer turns the sink back on. Only a falling edge of trig_i turns it back on.
- R9: In sync mode, a falling edge of trig_i while the current-limit flag is high leaves the sink off.
- R10: In sync mode, a falling edge of trig_i that arrives while the dead-time counter is running is ignored, and the sink stays off after the dead time ends.
- R11: Any one of the overtemperature, undervoltage or source-overcurrent flags turns all four gates off. When the flags clear, the bridge returns to its previous state with no dead time.
- R12: Each input reaches the logic through SYNC_STAGES flops. With the default of 2, a change driven between edges shows at the outputs after the second following rising edge and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Bridge enable, asynchronous |
| phase_i | input | 1 | Current direction select, asynchronous |
| over_nom_i | input | 1 | Actual current above nominal, asynchronous |
| trig_i | input | 1 | External sync trigger (falling edge active), asynchronous |
| sync_mode_i | input | 1 | 1 = sync mode, 0 = free-running chopper |
| otemp_i | input | 1 | Overtemperature flag |
| uvolt_i | input | 1 | Undervoltage flag |
| ocur_i | input | 1 | Source-side overcurrent flag |
| src1_o | output | 1 | High-side gate, leg 1 |
| src2_o | output | 1 | High-side gate, leg 2 |
| snk1_o | output | 1 | Low-side gate, leg 1 (chopped) |
| snk2_o | output | 1 | Low-side gate, leg 2 (chopped) |

## Verification
The bench counts the all-off window after a phase change. A counter loaded with an off-by-one value, or a design that skips the dead time, gives the wrong count, and skipping it would also show both diagonals overlapping. In free-running mode it fires the current limit right after sink turn-on. A design that cut the charge interval short would turn the sink back on after only the off interval, so the turn-on period would come out wrong. In sync mode it sends trigger edges while the limit is active and while the dead time is running. A design missing either guard would turn the sink on in the wrong place. After each fault it checks that the bridge comes back at once. A design that latched faults would stay off, and one that inserted a dead time on recovery would show the gates still at zero when they should be on.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

   typedef enum logic [1:0] {
      CH_CHARGE = 2'd0,
      CH_ARMED  = 2'd1,
      CH_OFF    = 2'd2
   } chop_st_e;

   typedef struct packed {
      logic src1;
      logic src2;
      logic snk1;
      logic snk2;
   } gate_t;

   localparam int unsigned IN_W = 8;

endpackage

// File: rtl/hbc_sync.sv
module hbc_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [STAGES-1:0][W-1:0] stg_q;

   initial begin
      assert (STAGES >= 2) else $error("hbc_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int i = 1; i < int'(STAGES); i++) begin
            stg_q[i] <= stg_q[i-1];
         end
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/hbc_chop.sv
module hbc_chop
   import hbc_pkg::*;
#(
   parameter int unsigned CHG_CYC = 400,
   parameter int unsigned OFF_CYC = 1600
) (
   input  logic clk,
   input  logic rst_n,
   input  logic over_s,
   input  logic trig_s,
   input  logic sync_mode,
   input  logic hold,
   output logic latch_o
);

   localparam int unsigned MAXC = (CHG_CYC > OFF_CYC) ? CHG_CYC : OFF_CYC;
   localparam int unsigned CW   = $clog2(MAXC + 1);

   chop_st_e        st_q, st_d;
   logic [CW-1:0]   cnt_q, cnt_d;
   logic            latch_q, latch_d;
   logic            trig_d_q;
   logic            trig_fall;
   logic            set_free, set_sync;

   initial begin
      assert (CHG_CYC >= 2) else $error("hbc_chop: CHG_CYC must be at least 2");
      assert (OFF_CYC >= 1) else $error("hbc_chop: OFF_CYC must be at least 1");
   end

   assign trig_fall = trig_d_q & ~trig_s;
   assign set_sync  = sync_mode & trig_fall & ~over_s & ~hold;

   always_comb begin
      st_d     = st_q;
      cnt_d    = cnt_q;
      set_free = 1'b0;
      if (sync_mode) begin
         st_d  = CH_CHARGE;
         cnt_d = CW'(CHG_CYC);
      end else begin
         case (st_q)
            CH_CHARGE: begin
               if (cnt_q <= CW'(1)) begin
                  st_d  = latch_q ? CH_ARMED : CH_OFF;
                  cnt_d = CW'(OFF_CYC);
               end else begin
                  cnt_d = cnt_q - CW'(1);
               end
            end
            CH_ARMED: begin
               if (!latch_q || over_s) begin
                  st_d  = CH_OFF;
                  cnt_d = CW'(OFF_CYC);
               end
            end
            CH_OFF: begin
               if (cnt_q <= CW'(1)) begin
                  set_free = 1'b1;
                  st_d     = CH_CHARGE;
                  cnt_d    = CW'(CHG_CYC);
               end else begin
                  cnt_d = cnt_q - CW'(1);
               end
            end
            default: begin
               st_d  = CH_CHARGE;
               cnt_d = CW'(CHG_CYC);
            end
         endcase
      end
   end

   always_comb begin
      if (over_s)                    latch_d = 1'b0;
      else if (set_free || set_sync) latch_d = 1'b1;
      else                           latch_d = latch_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= CH_CHARGE;
         cnt_q    <= CW'(CHG_CYC);
         latch_q  <= 1'b1;
         trig_d_q <= 1'b0;
      end else begin
         st_q     <= st_d;
         cnt_q    <= cnt_d;
         latch_q  <= latch_d;
         trig_d_q <= trig_s;
      end
   end

   assign latch_o = latch_q;

   // R5: a seen current limit always clears the latch
   a_r5_limit_clears: assert property (@(posedge clk) disable iff (!rst_n)
      over_s |=> !latch_q);

   // R8: in sync mode the latch rises only on a trigger edge
   a_r8_no_timer_set: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_mode && !latch_q && !trig_fall) |=> !latch_q);

   // R10: trigger edges during dead time do not set the latch
   a_r10_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_mode && hold && !latch_q) |=> !latch_q);

   // R7: the off interval never runs with the sink enabled
   a_r7_off_is_low: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == CH_OFF) |-> !latch_q);

endmodule

// File: rtl/hbc_phase.sv
module hbc_phase
   import hbc_pkg::*;
#(
   parameter int unsigned DEAD_CYC = 1000
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  en_s,
   input  logic  ph_s,
   input  logic  fault_s,
   input  logic  sink_on,
   output logic  dead_o,
   output gate_t gate_o
);

   localparam int unsigned DW = $clog2(DEAD_CYC + 1);

   logic [DW-1:0] dead_q;
   logic          cur_ph_q;
   logic          active;

   initial begin
      assert (DEAD_CYC >= 1) else $error("hbc_phase: DEAD_CYC must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dead_q   <= '0;
         cur_ph_q <= 1'b0;
      end else if (!en_s) begin
         dead_q   <= '0;
         cur_ph_q <= ph_s;
      end else if (dead_q != '0) begin
         dead_q <= dead_q - DW'(1);
      end else if (ph_s != cur_ph_q) begin
         dead_q   <= DW'(DEAD_CYC);
         cur_ph_q <= ph_s;
      end
   end

   assign active      = en_s & (dead_q == '0) & ~fault_s;
   assign dead_o      = (dead_q != '0);
   assign gate_o.src1 = active &  cur_ph_q;
   assign gate_o.src2 = active & ~cur_ph_q;
   assign gate_o.snk1 = active & ~cur_ph_q & sink_on;
   assign gate_o.snk2 = active &  cur_ph_q & sink_on;

   // R4: a running dead-time counter steps down by one each cycle
   a_r4_dead_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (en_s && dead_q != '0) |=> (dead_q == $past(dead_q) - DW'(1)));

   // R1: disabling clears any dead time in progress
   a_r1_dead_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      !en_s |=> (dead_q == '0));

endmodule

// File: rtl/hbridge_chop_ctrl.sv
module hbridge_chop_ctrl
   import hbc_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DEAD_CYC    = 1000,
   parameter int unsigned CHG_CYC     = 400,
   parameter int unsigned OFF_CYC     = 1600
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic phase_i,
   input  logic over_nom_i,
   input  logic trig_i,
   input  logic sync_mode_i,
   input  logic otemp_i,
   input  logic uvolt_i,
   input  logic ocur_i,
   output logic src1_o,
   output logic src2_o,
   output logic snk1_o,
   output logic snk2_o
);

   logic [IN_W-1:0] raw, syn;
   logic            en_s, ph_s, over_s, trig_s, mode_s, fault_s;
   logic            dead, latch;
   gate_t           gate;

   assign raw = {ocur_i, uvolt_i, otemp_i, sync_mode_i,
                 trig_i, over_nom_i, phase_i, en_i};

   hbc_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw),
      .q_o   (syn)
   );

   assign en_s    = syn[0];
   assign ph_s    = syn[1];
   assign over_s  = syn[2];
   assign trig_s  = syn[3];
   assign mode_s  = syn[4];
   assign fault_s = |syn[7:5];

   hbc_chop #(.CHG_CYC(CHG_CYC), .OFF_CYC(OFF_CYC)) u_chop (
      .clk       (clk),
      .rst_n     (rst_n),
      .over_s    (over_s),
      .trig_s    (trig_s),
      .sync_mode (mode_s),
      .hold      (dead),
      .latch_o   (latch)
   );

   hbc_phase #(.DEAD_CYC(DEAD_CYC)) u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_s    (en_s),
      .ph_s    (ph_s),
      .fault_s (fault_s),
      .sink_on (latch),
      .dead_o  (dead),
      .gate_o  (gate)
   );

   assign src1_o = gate.src1;
   assign src2_o = gate.src2;
   assign snk1_o = gate.snk1;
   assign snk2_o = gate.snk2;

   // R4: no leg ever has source and sink on together
   a_r4_no_shoot: assert property (@(posedge clk) disable iff (!rst_n)
      !(src1_o && snk1_o) && !(src2_o && snk2_o));

   // R11: a synchronized fault leaves every gate off
   a_r11_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
      fault_s |-> !(src1_o || src2_o || snk1_o || snk2_o));

   // R1: disabled bridge drives nothing
   a_r1_disabled_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en_s |-> ({src1_o, src2_o, snk1_o, snk2_o} == 4'b0000));

endmodule

// File: tb/sim_hbridge_chop_ctrl.sv
module sim_hbridge_chop_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int DEAD = 8;
   localparam int CHG  = 12;
   localparam int OFF  = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 0, ph = 0, over = 0, trig = 0, smode = 0;
   logic otemp = 0, uvolt = 0, ocur = 0;
   logic src1, src2, snk1, snk2;
   int   checks = 0;
   int   fails  = 0;
   bit   done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hbridge_chop_ctrl #(.SYNC_STAGES(2), .DEAD_CYC(DEAD), .CHG_CYC(CHG), .OFF_CYC(OFF)) u0 (
      .clk(clk), .rst_n(rst_n), .en_i(en), .phase_i(ph), .over_nom_i(over),
      .trig_i(trig), .sync_mode_i(smode), .otemp_i(otemp), .uvolt_i(uvolt),
      .ocur_i(ocur), .src1_o(src1), .src2_o(src2), .snk1_o(snk1), .snk2_o(snk2)
   );

   function automatic logic [3:0] outs();
      return {src1, src2, snk1, snk2};
   endfunction

   task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic chk_n(input int act, input int exp, input string tag);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_over();
      over = 1'b1;
      step(1);
      over = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      step(5);
      chk(outs(), 4'b0000, "R1 reset state");
      rst_n = 1'b1;
      step(3);
      chk(outs(), 4'b0000, "R1 enable low after reset");
   endtask

   task automatic t_latency_and_phase0();
      en = 1'b1; ph = 1'b0;
      step(1);
      chk(outs(), 4'b0000, "R12 one edge after enable");
      step(1);
      chk(outs(), 4'b0110, "R2 phase low diagonal");
   endtask

   task automatic t_dead_time();
      int g = 0;
      int n = 0;
      ph = 1'b1;
      step(1);
      while (outs() != 4'b0000 && g < 20) begin step(1); g++; end
      while (outs() == 4'b0000 && n < 100) begin n++; step(1); end
      chk_n(n, DEAD, "R4 dead time length");
      chk(outs(), 4'b1001, "R3 phase high diagonal");
   endtask

   task automatic t_enable();
      en = 1'b0;
      step(3);
      chk(outs(), 4'b0000, "R1 enable low all off");
      en = 1'b1;
      step(3);
      chk(outs(), 4'b1001, "R1 re-enable without dead time");
   endtask

   task automatic t_free_run();
      int n = 0;
      int g = 0;
      bit seen_low = 0;
      step(CHG + 5);
      pulse_over();
      while (snk2 && g < 20) begin step(1); g++; end
      chk(outs(), 4'b1000, "R5 sink off source kept");
      while (!snk2 && n < 200) begin n++; step(1); end
      chk_n(n, OFF, "R6 off interval length");
      pulse_over();
      n = 1;
      while (n < 300) begin
         if (!snk2) seen_low = 1;
         if (snk2 && seen_low) break;
         step(1);
         n++;
      end
      chk_n(n, CHG + OFF, "R7 charge completes before off");
   endtask

   task automatic t_sync();
      smode = 1'b1; trig = 1'b1;
      step(4);
      pulse_over();
      step(5);
      chk(outs(), 4'b1000, "R5 sync limit clears sink");
      step(3 * (CHG + OFF));
      chk(outs(), 4'b1000, "R8 no timer restart in sync mode");
      over = 1'b1;
      step(1);
      trig = 1'b0;
      step(5);
      chk(outs(), 4'b1000, "R9 edge ignored above nominal");
      trig = 1'b1;
      step(3);
      over = 1'b0;
      step(4);
      chk(outs(), 4'b1000, "R8 no set without edge");
      trig = 1'b0;
      step(5);
      chk(outs(), 4'b1001, "R8 falling edge restores sink");
   endtask

   task automatic t_sync_dead();
      trig = 1'b1;
      step(3);
      pulse_over();
      step(5);
      chk(outs(), 4'b1000, "R10 sink cleared before phase change");
      ph = 1'b0;
      step(3);
      trig = 1'b0;
      step(DEAD + 10);
      chk(outs(), 4'b0100, "R10 edge during dead time ignored");
      trig = 1'b1;
      step(3);
      trig = 1'b0;
      step(5);
      chk(outs(), 4'b0110, "R10 edge after dead time accepted");
   endtask

   task automatic t_faults();
      for (int k = 0; k < 3; k++) begin
         otemp = (k == 0); uvolt = (k == 1); ocur = (k == 2);
         step(4);
         chk(outs(), 4'b0000, $sformatf("R11 fault %0d forces off", k));
         otemp = 1'b0; uvolt = 1'b0; ocur = 1'b0;
         step(3);
         chk(outs(), 4'b0110, $sformatf("R11 fault %0d recovery", k));
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      step(1);
      t_reset();
      t_latency_and_phase0();
      t_dead_time();
      t_enable();
      t_free_run();
      t_sync();
      t_sync_dead();
      t_faults();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule